// File: doc/BRIEF.md
# External Memory Strobe Timing Sequencer

This block produces the address, strobe and data-driver timing for a single external memory bank that uses a NAND Flash or PC Card style asynchronous interface. The host logic issues a request with a direction (read or write), a space select (common or attribute), an address and write data. The block then runs four phases in order: address setup, command strobe, hold, and return to idle. On writes, a data-bus high-impedance window runs in parallel with these phases, starting from the first cycle of the access.

The common space and the attribute space each have their own group of four 8-bit timing fields. These groups are loaded through a simple configuration write port. Because the attribute group is chosen per request, the final address cycle of a NAND sequence can use timing that differs from the earlier cycles. The command strobe has a programmed minimum length, and an external active-low wait line can hold it longer.

A reserved field value is clamped to the nearest legal value when it is loaded, and a sticky error flag records that this happened. Each access ends with a one-cycle done pulse. On a read, the captured data is presented together with that pulse.

Top module: `xmem_strobe_seq`

## Requirements
- R1: After reset, `req_ready` is 1, both strobes are high, `mem_dout_en` is 0, `done` is 0 and `cfg_err` is 0. Every timing field of both spaces holds 0xFC.
- R2: A cycle with `cfg_we` high loads `cfg_data` into the timing group picked by `cfg_space` (0 = common, 1 = attribute). The packing is setup in bits [7:0], command in [15:8], Hi-Z in [23:16] and hold in [31:24].
- R3: An accepted access keeps both strobes high for setup+1 cycles, counted from the first cycle after acceptance.
- R4: During the command phase only one strobe is low: `mem_we_n` for writes, `mem_oe_n` for reads. With `mem_wait_n` high, it stays low for exactly command+1 cycles. Both strobes are never low together, and neither is low while the block is idle.
- R5: If `mem_wait_n` is low in the last programmed command cycle, the strobe stays low until the cycle in which `mem_wait_n` is sampled high. That cycle is the last one with the strobe low.
- R6: The hold phase lasts hold cycles with both strobes high. `mem_addr` (and `mem_dout` on writes) stays constant for the whole access. `req_ready` returns to 1 on the cycle after the last hold cycle.
- R7: On a write, `mem_dout_en` is 0 for the first Hi-Z cycles of the access and then 1 until the access ends. On a read, `mem_dout_en` stays 0.
- R8: `done` is high for exactly one cycle, the first hold cycle. On a read, `rdata` then holds the `mem_din` value sampled on the clock edge that ends the strobe.
- R9: `req_attr` = 1 times the access with the attribute group, and `req_attr` = 0 times it with the common group.
- R10: A loaded value of 0xFF in any field is clamped to 0xFE. A value of 0x00 in the command or hold field is clamped to 0x01. Loading any reserved value sets `cfg_err`, which then stays 1 until reset.
- R11: A request is accepted only when `req_ready` is 1. A request raised during an access has no effect on the current access, and no access starts after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing group load strobe |
| cfg_space | input | 1 | Group to load: 0 common, 1 attribute |
| cfg_data | input | 32 | Packed timing fields {hold, hiz, cmd, setup} |
| cfg_err | output | 1 | Sticky flag: a reserved field value was loaded |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute timing, 0 = common timing |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Address to memory |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_dout | output | DATA_W | Write data to memory |
| mem_dout_en | output | 1 | Data bus output driver enable |
| mem_din | input | DATA_W | Read data from memory |
| mem_wait_n | input | 1 | Active-low wait from memory |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
A wrong phase counter shows up right away as a wrong number of cycles in one of the measured windows. That window is strobe-high before the strobe, strobe-low, or strobe-high before `req_ready`, and the error is visible within the access in which it happens. A stale latched direction or timing selection appears as the wrong strobe or the wrong group's lengths on the next access. A broken clamp or error flag is seen on the first access after the load, through the cycle counts and `cfg_err`. A faulty read capture or done generation appears in the first hold cycle as a missing or doubled pulse or as a wrong `rdata`.

// File: rtl/xmem_seq_pkg.sv
package xmem_seq_pkg;

    localparam int FIELD_W = 8;
    localparam int NSPACE  = 2;
    localparam int CFG_W   = 4 * FIELD_W;

    typedef logic [FIELD_W-1:0] field_t;

    localparam field_t FIELD_RST  = field_t'(8'hFC);
    localparam field_t FIELD_RSVD = field_t'(8'hFF);
    localparam field_t FIELD_TOP  = field_t'(8'hFE);
    localparam field_t FIELD_ONE  = field_t'(1);

    typedef struct packed {
        field_t hold;
        field_t hiz;
        field_t cmd;
        field_t setup;
    } timing_t;

    localparam timing_t TIMING_RST = '{hold: FIELD_RST, hiz: FIELD_RST,
                                       cmd: FIELD_RST, setup: FIELD_RST};

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    function automatic logic bad_field(input field_t v, input logic zero_bad);
        return (v == FIELD_RSVD) || (zero_bad && (v == '0));
    endfunction

    function automatic field_t fix_field(input field_t v, input logic zero_bad);
        if (v == FIELD_RSVD)
            return FIELD_TOP;
        else if (zero_bad && (v == '0))
            return FIELD_ONE;
        return v;
    endfunction

    function automatic timing_t fix_timing(input timing_t t);
        timing_t r;
        r.setup = fix_field(t.setup, 1'b0);
        r.cmd   = fix_field(t.cmd,   1'b1);
        r.hiz   = fix_field(t.hiz,   1'b0);
        r.hold  = fix_field(t.hold,  1'b1);
        return r;
    endfunction

    function automatic logic bad_timing(input timing_t t);
        return bad_field(t.setup, 1'b0) || bad_field(t.cmd, 1'b1) ||
               bad_field(t.hiz, 1'b0)   || bad_field(t.hold, 1'b1);
    endfunction

endpackage

// File: rtl/xmem_cfg_bank.sv
module xmem_cfg_bank
    import xmem_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cfg_we,
    input  logic    cfg_space,
    input  timing_t cfg_data,
    input  logic    sel_space,
    output timing_t sel_timing,
    output logic    cfg_err
);

    timing_t bank [NSPACE];

    for (genvar i = 0; i < NSPACE; i++) begin : g_space
        timing_t grp_q;
        always_ff @(posedge clk) begin
            if (rst)
                grp_q <= TIMING_RST;
            else if (cfg_we && (cfg_space == 1'(i)))
                grp_q <= fix_timing(cfg_data);
        end
        assign bank[i] = grp_q;
    end

    assign sel_timing = bank[sel_space];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_err <= 1'b0;
        else if (cfg_we && bad_timing(cfg_data))
            cfg_err <= 1'b1;
    end

endmodule

// File: rtl/xmem_phase_fsm.sv
module xmem_phase_fsm
    import xmem_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  timing_t tim_in,
    input  logic    mem_wait_n,
    output phase_e  phase,
    output logic    leave_cmd
);

    phase_e ph_q;
    field_t cnt_q;
    field_t cmd_q;
    field_t hold_q;

    assign phase     = ph_q;
    assign leave_cmd = (ph_q == PH_CMD) && (cnt_q == '0) && mem_wait_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            cmd_q  <= '0;
            hold_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        ph_q   <= PH_SETUP;
                        cnt_q  <= tim_in.setup;
                        cmd_q  <= tim_in.cmd;
                        hold_q <= tim_in.hold;
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        ph_q  <= PH_CMD;
                        cnt_q <= cmd_q;
                    end else begin
                        cnt_q <= cnt_q - FIELD_ONE;
                    end
                end
                PH_CMD: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - FIELD_ONE;
                    end else if (mem_wait_n) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= hold_q - FIELD_ONE;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0)
                        ph_q <= PH_IDLE;
                    else
                        cnt_q <= cnt_q - FIELD_ONE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xmem_bus_drv.sv
module xmem_bus_drv
    import xmem_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  field_t            hiz_in,
    input  phase_e            phase,
    input  logic              leave_cmd,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    field_t            hiz_q;
    logic              busy;

    assign busy = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            hiz_q  <= '0;
        end else if (start) begin
            wr_q   <= req_write;
            addr_q <= req_addr;
            data_q <= req_wdata;
            hiz_q  <= hiz_in;
        end else if (busy && (hiz_q != '0)) begin
            hiz_q  <= hiz_q - FIELD_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= leave_cmd;
            if (leave_cmd && !wr_q)
                rdata <= mem_din;
        end
    end

    assign mem_addr    = addr_q;
    assign mem_dout    = data_q;
    assign mem_dout_en = busy && wr_q && (hiz_q == '0);
    assign mem_we_n    = !((phase == PH_CMD) && wr_q);
    assign mem_oe_n    = !((phase == PH_CMD) && !wr_q);

endmodule

// File: rtl/xmem_strobe_seq.sv
module xmem_strobe_seq
    import xmem_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_space,
    input  logic [CFG_W-1:0]  cfg_data,
    output logic              cfg_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_attr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_wait_n,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    timing_t sel_timing;
    phase_e  phase;
    logic    leave_cmd;
    logic    start;

    assign req_ready = (phase == PH_IDLE);
    assign start     = req_valid && req_ready;

    xmem_cfg_bank u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_space  (cfg_space),
        .cfg_data   (timing_t'(cfg_data)),
        .sel_space  (req_attr),
        .sel_timing (sel_timing),
        .cfg_err    (cfg_err)
    );

    xmem_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .tim_in     (sel_timing),
        .mem_wait_n (mem_wait_n),
        .phase      (phase),
        .leave_cmd  (leave_cmd)
    );

    xmem_bus_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_drv (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .hiz_in      (sel_timing.hiz),
        .phase       (phase),
        .leave_cmd   (leave_cmd),
        .mem_din     (mem_din),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .done        (done),
        .rdata       (rdata)
    );

endmodule

// File: rtl/xmem_strobe_seq_chk.sv
module xmem_strobe_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_err,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dout_en,
    input logic              done
);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));

    assert_strobe_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> !req_ready);

    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> (req_ready || $stable(mem_addr)));

    assert_drv_busy_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> (!req_ready && mem_oe_n));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (mem_we_n && mem_oe_n && $past(!mem_we_n || !mem_oe_n)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind xmem_strobe_seq xmem_strobe_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_err     (cfg_err),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_addr    (mem_addr),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dout_en (mem_dout_en),
    .done        (done)
);

// File: tb/xmem_strobe_seq_tb.sv
module xmem_strobe_seq_tb;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic          cfg_space;
    logic [31:0]   cfg_data;
    logic          cfg_err;
    logic          req_valid;
    logic          req_ready;
    logic          req_write;
    logic          req_attr;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_we_n;
    logic          mem_oe_n;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;
    logic          mem_wait_n;
    logic          done;
    logic [DW-1:0] rdata;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xmem_strobe_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_space(cfg_space),
        .cfg_data(cfg_data), .cfg_err(cfg_err), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_attr(req_attr),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_wait_n(mem_wait_n),
        .done(done), .rdata(rdata)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(input logic sp, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_space = sp; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access and measures every phase at the ports.
    task automatic run_access(input bit wr, input bit attr, input logic [AW-1:0] addr,
                              input logic [DW-1:0] wd, input logic [DW-1:0] din,
                              input bit hold_wait, input bit poke,
                              input int exp_s, input int exp_c, input int exp_h,
                              input int exp_z, input string tag);
        int s = 0, c = 0, h = 0, z = 0, cyc = 0, done_cnt = 0, done_at = -1;
        bit z_end = 0, addr_bad = 0, data_bad = 0, wrong_strobe = 0, rd_drv = 0;
        logic [DW-1:0] rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_attr = attr;
        req_addr = addr; req_wdata = wd; mem_din = din;
        mem_wait_n = hold_wait ? 1'b0 : 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && cyc < 2000) begin
            cyc++;
            if (wr ? !mem_oe_n : !mem_we_n) wrong_strobe = 1;
            if (wr ? !mem_we_n : !mem_oe_n) begin
                c++;
                if (hold_wait && c == exp_c) mem_wait_n = 1'b1;
            end else if (c == 0) s++;
            else h++;
            if (wr && !mem_dout_en && !z_end) z++;
            else z_end = 1;
            if (!wr && mem_dout_en) rd_drv = 1;
            if (done) begin done_cnt++; done_at = cyc; rd = rdata; end
            if (mem_addr != addr) addr_bad = 1;
            if (wr && mem_dout != wd) data_bad = 1;
            if (poke && cyc == 2) begin
                req_valid = 1'b1; req_write = !wr; req_addr = ~addr;
            end
            if (poke && cyc == 3) req_valid = 1'b0;
            @(negedge clk);
        end
        mem_wait_n = 1'b1;
        check_eq("R3", {tag, " setup cycles"}, s, exp_s);
        check_eq(hold_wait ? "R5" : "R4", {tag, " strobe cycles"}, c, exp_c);
        check_eq("R4", {tag, " wrong strobe"}, int'(wrong_strobe), 0);
        check_eq("R6", {tag, " hold cycles"}, h, exp_h);
        check_eq("R6", {tag, " address moved"}, int'(addr_bad), 0);
        if (wr) begin
            check_eq("R7", {tag, " hi-z cycles"}, z, exp_z);
            check_eq("R6", {tag, " write data moved"}, int'(data_bad), 0);
        end else begin
            check_eq("R7", {tag, " driver on in read"}, int'(rd_drv), 0);
            check_eq("R8", {tag, " read data"}, int'(rd), int'(din));
        end
        check_eq("R8", {tag, " done count"}, done_cnt, 1);
        check_eq("R8", {tag, " done cycle"}, done_at, exp_s + exp_c + 1);
        check_eq("R6", {tag, " ready after hold"}, int'(req_ready), 1);
        check_eq("R8", {tag, " done low when idle"}, int'(done), 0);
    endtask

    task automatic t_reset_R1();
        check_eq("R1", "ready", int'(req_ready), 1);
        check_eq("R1", "we_n", int'(mem_we_n), 1);
        check_eq("R1", "oe_n", int'(mem_oe_n), 1);
        check_eq("R1", "dout_en", int'(mem_dout_en), 0);
        check_eq("R1", "done", int'(done), 0);
        check_eq("R1", "cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_default_R1();
        run_access(0, 0, 16'h1234, 8'h00, 8'h3C, 0, 0, 253, 253, 252, 0, "R1 default read");
        run_access(1, 1, 16'h4321, 8'h5A, 8'h00, 0, 0, 253, 253, 252, 252, "R1 default write");
    endtask

    task automatic t_common_write_R2();
        load_cfg(1'b0, 32'h0204_0302);
        run_access(1, 0, 16'hA0A0, 8'hC3, 8'h00, 0, 0, 3, 4, 2, 4, "R2 common write");
    endtask

    task automatic t_common_read_R2();
        load_cfg(1'b0, 32'h0100_0100);
        run_access(0, 0, 16'h0F0F, 8'h00, 8'hA5, 0, 0, 1, 2, 1, 0, "R2 short read");
        check_eq("R10", "legal load leaves err low", int'(cfg_err), 0);
    endtask

    task automatic t_attr_R9();
        load_cfg(1'b1, 32'h0301_0504);
        run_access(1, 1, 16'h5555, 8'h81, 8'h00, 0, 0, 5, 6, 3, 1, "R9 attr write");
        run_access(0, 0, 16'h6666, 8'h00, 8'h7E, 0, 0, 1, 2, 1, 0, "R9 common after attr");
    endtask

    task automatic t_wait_R5();
        run_access(0, 0, 16'h7777, 8'h00, 8'h19, 1, 0, 1, 5, 1, 0, "R5 read wait");
        run_access(1, 1, 16'h8888, 8'h42, 8'h00, 1, 0, 5, 8, 3, 1, "R5 attr write wait");
    endtask

    task automatic t_clamp_R10();
        check_eq("R10", "err before reserved", int'(cfg_err), 0);
        load_cfg(1'b0, 32'h00FF_00FF);
        check_eq("R10", "err after reserved", int'(cfg_err), 1);
        run_access(1, 0, 16'h9999, 8'hE7, 8'h00, 0, 0, 255, 2, 1, 254, "R10 clamped write");
        load_cfg(1'b0, 32'h0200_0302);
        check_eq("R10", "err sticky", int'(cfg_err), 1);
    endtask

    task automatic t_busy_R11();
        run_access(0, 0, 16'h1111, 8'h00, 8'hD2, 0, 1, 3, 4, 2, 0, "R11 poke read");
        @(negedge clk);
        check_eq("R11", "no access after poke", int'(req_ready), 1);
        check_eq("R11", "strobes idle after poke", int'(mem_we_n & mem_oe_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_space = 1'b0; cfg_data = '0;
        req_valid = 1'b0; req_write = 1'b0; req_attr = 1'b0;
        req_addr = '0; req_wdata = '0; mem_din = '0; mem_wait_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_R1();
        t_default_R1();
        t_common_write_R2();
        t_common_read_R2();
        t_attr_R9();
        t_wait_R5();
        t_clamp_R10();
        t_busy_R11();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule